// File: doc/BRIEF.md
# Four-Register Multicycle Processor Core

This block is a small processor core that runs a program held in a unified 256-word by 32-bit memory. Program and data share that memory. A bench or a loader writes the program from address 0 through a preload port while the core is idle. A `start` pulse then begins execution at address 0. Every instruction takes two clock cycles: one fetches the word and advances the instruction pointer, and one executes the word against four 32-bit general registers and the memory.

Each instruction word holds three byte fields. The operation code is in bits 7..0. The first operand is in bits 15..8 and the second operand is in bits 23..16. Both operand bytes are always extracted. All memory access is register-indirect. Branches test one register against zero and jump to an absolute address given as a literal. Two print operations send a 32-bit value out on a valid/data stream. The core stops on a halt instruction or on an undefined operation code, and an undefined code also raises a flag.

Top module: `tcore_top`

## Requirements
- R1: After reset, `halted`, `illegal` and `out_valid` are 0. The instruction pointer, all four registers and every memory word are zero. Preload writes (`load_en`) are accepted only while the core is idle, that is, after reset and before `start`.
- R2: Code 0x2 (load-constant) writes the second operand byte, zero-extended, into register[arg0]. Code 0xA (print-register) emits register[arg0] on `out_data` with `out_valid` high.
- R3: Code 0x6 sets register[arg0] to register[arg0] + register[arg1]. Code 0x7 sets register[arg0] to register[arg0] - register[arg1]. Both results wrap modulo 2^32.
- R4: Code 0x4 (copy) writes register[arg1] into register[arg0].
- R5: Code 0x5 writes register[arg0] to memory at address register[arg1]. Code 0x3 loads register[arg0] from memory at address register[arg1]. Only the low 8 bits of a register are used as the address.
- R6: Code 0x8 jumps to the second operand byte when register[arg0] is zero. Code 0x9 jumps there when register[arg0] is nonzero. When the branch is not taken, execution continues at the next word.
- R7: Code 0xB (print-memory) emits memory[register[arg0] low 8 bits]. A word that was not loaded reads as 0.
- R8: Code 0x1 (halt) raises `halted` and leaves it high until reset. After a halt, no further output appears, and `start` has no effect.
- R9: An operation code outside 0x1..0xB raises both `halted` and `illegal`. The undefined word is not executed.
- R10: A register selector uses only the low 2 bits of its operand byte. For example, byte 6 selects register 2.
- R11: `out_valid` rises two cycles after the edge that samples `start` when the first word is a print. Each print gives a one-cycle pulse. Consecutive instructions are two cycles apart. `halted` rises two cycles after the preceding instruction's effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (idle only) |
| load_en | input | 1 | Preload write strobe (idle only) |
| load_addr | input | 8 | Preload word address |
| load_data | input | 32 | Preload word value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined operation code |
| out_valid | output | 1 | One-cycle strobe for a printed value |
| out_data | output | 32 | Printed value, valid with `out_valid` |

## Verification
The registers and the memory are not visible at the ports, so a wrong internal value shows only when a print reaches it. For that reason each scenario ends with prints that carry the state it touched. A corrupted register or memory word appears as a wrong value on the stream. It shows up on the first print that reads that location, two cycles after that print is fetched. A wrong instruction pointer or a wrong branch decision shows as a missing, extra or reordered stream value, or as a halt in the wrong cycle. The timing checks count cycles from the edge that samples `start`.

// File: rtl/tcore_pkg.sv
package tcore_pkg;

    typedef enum logic [7:0] {
        OPC_HALT = 8'h01,
        OPC_LDC  = 8'h02,
        OPC_LDI  = 8'h03,
        OPC_MOV  = 8'h04,
        OPC_STI  = 8'h05,
        OPC_ADD  = 8'h06,
        OPC_SUB  = 8'h07,
        OPC_BZ   = 8'h08,
        OPC_BNZ  = 8'h09,
        OPC_PRG  = 8'h0A,
        OPC_PMEM = 8'h0B
    } opc_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FETCH,
        PH_EXEC,
        PH_STOP
    } phase_t;

endpackage

// File: rtl/tcore_mem.sv
module tcore_mem #(
    parameter int WORDS = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b
);
    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];

endmodule

// File: rtl/tcore_regs.sv
module tcore_regs #(
    parameter int NREG = 4,
    parameter int DW   = 32,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] sel_a,
    output logic [DW-1:0] val_a,
    input  logic [SW-1:0] sel_b,
    output logic [DW-1:0] val_b
);
    logic [DW-1:0] rf_q [NREG];
    logic [DW-1:0] rf_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            rf_d[g] = (we && (wsel == SW'(g))) ? wdata : rf_q[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rf_q[g] <= '0;
            end else begin
                rf_q[g] <= rf_d[g];
            end
        end
    end

    assign val_a = rf_q[sel_a];
    assign val_b = rf_q[sel_b];

endmodule

// File: rtl/tcore_exec.sv
module tcore_exec
    import tcore_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic [7:0]    opc,
    input  logic [7:0]    arg1,
    input  logic [DW-1:0] ra,
    input  logic [DW-1:0] rb,
    input  logic [DW-1:0] mrd,
    output logic [AW-1:0] maddr,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata,
    output logic          mem_we,
    output logic          take,
    output logic [AW-1:0] target,
    output logic          emit,
    output logic [DW-1:0] emit_data,
    output logic          stop,
    output logic          bad
);
    always_comb begin
        maddr     = (opc == OPC_PMEM) ? ra[AW-1:0] : rb[AW-1:0];
        reg_we    = 1'b0;
        reg_wdata = '0;
        mem_we    = 1'b0;
        take      = 1'b0;
        target    = arg1[AW-1:0];
        emit      = 1'b0;
        emit_data = '0;
        stop      = 1'b0;
        bad       = 1'b0;
        case (opc)
            OPC_HALT: stop = 1'b1;
            OPC_LDC: begin
                reg_we    = 1'b1;
                reg_wdata = DW'(arg1);
            end
            OPC_LDI: begin
                reg_we    = 1'b1;
                reg_wdata = mrd;
            end
            OPC_MOV: begin
                reg_we    = 1'b1;
                reg_wdata = rb;
            end
            OPC_STI: mem_we = 1'b1;
            OPC_ADD: begin
                reg_we    = 1'b1;
                reg_wdata = ra + rb;
            end
            OPC_SUB: begin
                reg_we    = 1'b1;
                reg_wdata = ra - rb;
            end
            OPC_BZ:  take = (ra == '0);
            OPC_BNZ: take = (ra != '0);
            OPC_PRG: begin
                emit      = 1'b1;
                emit_data = ra;
            end
            OPC_PMEM: begin
                emit      = 1'b1;
                emit_data = mrd;
            end
            default: begin
                stop = 1'b1;
                bad  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tcore_top.sv
module tcore_top
    import tcore_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int NREG      = 4,
    parameter int DW        = 32,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int SW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic          halted,
    output logic          illegal,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        phase_t        phase;
        logic [AW-1:0] ip;
        logic [DW-1:0] instr;
        logic          ovalid;
        logic [DW-1:0] odata;
        logic          bad;
    } core_t;

    core_t core_d, core_q;

    logic [7:0]    f_opc, f_arg0, f_arg1;
    logic [DW-1:0] ra, rb, fetch_word, mrd;
    logic [AW-1:0] x_maddr, x_target;
    logic          x_reg_we, x_mem_we, x_take, x_emit, x_stop, x_bad;
    logic [DW-1:0] x_reg_wdata, x_emit_data;
    logic          mem_we, rf_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    assign f_opc  = core_q.instr[7:0];
    assign f_arg0 = core_q.instr[15:8];
    assign f_arg1 = core_q.instr[23:16];

    tcore_mem #(.WORDS(MEM_WORDS), .DW(DW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mem_we),
        .wr_addr   (mem_waddr),
        .wr_data   (mem_wdata),
        .rd_addr_a (core_q.ip),
        .rd_data_a (fetch_word),
        .rd_addr_b (x_maddr),
        .rd_data_b (mrd)
    );

    tcore_regs #(.NREG(NREG), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wsel  (f_arg0[SW-1:0]),
        .wdata (x_reg_wdata),
        .sel_a (f_arg0[SW-1:0]),
        .val_a (ra),
        .sel_b (f_arg1[SW-1:0]),
        .val_b (rb)
    );

    tcore_exec #(.DW(DW), .AW(AW)) u_exec (
        .opc       (f_opc),
        .arg1      (f_arg1),
        .ra        (ra),
        .rb        (rb),
        .mrd       (mrd),
        .maddr     (x_maddr),
        .reg_we    (x_reg_we),
        .reg_wdata (x_reg_wdata),
        .mem_we    (x_mem_we),
        .take      (x_take),
        .target    (x_target),
        .emit      (x_emit),
        .emit_data (x_emit_data),
        .stop      (x_stop),
        .bad       (x_bad)
    );

    always_comb begin
        core_d        = core_q;
        core_d.ovalid = 1'b0;
        mem_we        = 1'b0;
        mem_waddr     = load_addr;
        mem_wdata     = load_data;
        rf_we         = 1'b0;
        case (core_q.phase)
            PH_IDLE: begin
                mem_we = load_en;
                if (start) begin
                    core_d.phase = PH_FETCH;
                end
            end
            PH_FETCH: begin
                core_d.instr = fetch_word;
                core_d.ip    = core_q.ip + 1'b1;
                core_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                rf_we     = x_reg_we;
                mem_we    = x_mem_we;
                mem_waddr = x_maddr;
                mem_wdata = ra;
                if (x_take) begin
                    core_d.ip = x_target;
                end
                if (x_emit) begin
                    core_d.ovalid = 1'b1;
                    core_d.odata  = x_emit_data;
                end
                if (x_stop) begin
                    core_d.phase = PH_STOP;
                    core_d.bad   = x_bad;
                end else begin
                    core_d.phase = PH_FETCH;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '{phase: PH_IDLE, ip: '0, instr: '0, ovalid: 1'b0,
                        odata: '0, bad: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign halted    = (core_q.phase == PH_STOP);
    assign illegal   = core_q.bad;
    assign out_valid = core_q.ovalid;
    assign out_data  = core_q.odata;

    // R8
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !out_valid);

    // R9
    bad_means_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R11
    emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R1
    idle_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && core_q.phase != PH_EXEC) |-> (core_q.phase == PH_IDLE));

    // R11
    fetch_exec_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.phase == PH_FETCH) |=> (core_q.phase == PH_EXEC));

endmodule

// File: tb/tb_tcore_top.sv
module tb_tcore_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic        halted, illegal, out_valid;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int start_cyc = 0;
    logic [31:0] seen[$];
    int seen_cyc[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tcore_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
        .load_addr(load_addr), .load_data(load_data), .halted(halted),
        .illegal(illegal), .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen.push_back(out_data);
            seen_cyc.push_back(cyc);
        end
    end

    function automatic logic [31:0] w(logic [7:0] op, logic [7:0] a0, logic [7:0] a1);
        return {8'h00, a1, a0, op};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen.delete();
        seen_cyc.delete();
    endtask

    task automatic put(int a, logic [31:0] d);
        load_en = 1'b1;
        load_addr = 8'(a);
        load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        @(posedge clk);
        start_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_stop(int lim);
        for (int i = 0; i < lim && !halted; i++) @(negedge clk);
    endtask

    task automatic chk_stream(string req, logic [31:0] exp[$]);
        chk({req, " count"}, 32'(seen.size()), 32'(exp.size()));
        for (int i = 0; i < exp.size() && i < seen.size(); i++)
            chk(req, seen[i], exp[i]);
    endtask

    task automatic t_reset();
        do_reset();
        // R1
        chk("R1 halted", 32'(halted), 0);
        chk("R1 illegal", 32'(illegal), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
    endtask

    task automatic t_arith();
        logic [31:0] e[$];
        do_reset();
        put(0, w(8'h02, 0, 3));  put(1, w(8'h02, 1, 4));
        put(2, w(8'h06, 0, 1));  put(3, w(8'h0A, 0, 0));
        put(4, w(8'h02, 2, 0));  put(5, w(8'h02, 3, 1));
        put(6, w(8'h07, 2, 3));  put(7, w(8'h0A, 2, 0));
        put(8, w(8'h06, 2, 3));  put(9, w(8'h0A, 2, 0));
        put(10, w(8'h04, 1, 0)); put(11, w(8'h0A, 1, 0));
        put(12, w(8'h01, 0, 0));
        go();
        wait_stop(200);
        // R2 R3 R4: 3+4, 0-1 wraps, +1 wraps to 0, copy
        e = '{32'd7, 32'hFFFF_FFFF, 32'd0, 32'd7};
        chk_stream("R3", e);
        chk("R2 halted", 32'(halted), 1);
    endtask

    task automatic t_memory();
        logic [31:0] e[$];
        do_reset();
        put(0, w(8'h02, 1, 255)); put(1, w(8'h02, 2, 21));
        put(2, w(8'h06, 1, 2));   put(3, w(8'h02, 0, 99));
        put(4, w(8'h05, 0, 1));   put(5, w(8'h02, 3, 20));
        put(6, w(8'h03, 2, 3));   put(7, w(8'h0A, 2, 0));
        put(8, w(8'h0B, 3, 0));   put(9, w(8'h02, 3, 100));
        put(10, w(8'h0B, 3, 0));  put(11, w(8'h02, 6, 55));
        put(12, w(8'h0A, 2, 0));  put(13, w(8'h01, 0, 0));
        go();
        wait_stop(200);
        // R5 (address 276 -> 20), R7 (unloaded word 0), R10 (selector 6 -> reg 2)
        e = '{32'd99, 32'd99, 32'd0, 32'd55};
        chk_stream("R5", e);
        if (seen.size() == 4) begin
            chk("R7 unloaded", seen[2], 0);
            chk("R10 selector", seen[3], 55);
        end
    endtask

    task automatic t_branch();
        logic [31:0] e[$];
        do_reset();
        put(0, w(8'h02, 0, 0));  put(1, w(8'h02, 1, 3));
        put(2, w(8'h0A, 0, 0));  put(3, w(8'h02, 2, 1));
        put(4, w(8'h06, 0, 2));  put(5, w(8'h04, 2, 1));
        put(6, w(8'h07, 2, 0));  put(7, w(8'h09, 2, 2));
        put(8, w(8'h08, 2, 10)); put(9, w(8'h0A, 1, 0));
        put(10, w(8'h0A, 0, 0)); put(11, w(8'h01, 0, 0));
        go();
        wait_stop(400);
        // R6: loop back while nonzero, fall through, taken zero branch skips word 9
        e = '{32'd0, 32'd1, 32'd2, 32'd3};
        chk_stream("R6", e);
    endtask

    task automatic t_halt();
        do_reset();
        put(0, w(8'h02, 0, 5)); put(1, w(8'h01, 0, 0)); put(2, w(8'h0A, 0, 0));
        go();
        wait_stop(50);
        // R8
        chk("R8 halted", 32'(halted), 1);
        chk("R8 illegal", 32'(illegal), 0);
        go();
        repeat (20) @(negedge clk);
        chk("R8 still halted", 32'(halted), 1);
        chk("R8 no output", 32'(seen.size()), 0);
    endtask

    task automatic t_illegal();
        logic [31:0] e[$];
        do_reset();
        put(0, w(8'h02, 0, 1)); put(1, w(8'h0A, 0, 0));
        put(2, 32'h0000_000C); put(3, w(8'h0A, 0, 0));
        go();
        wait_stop(50);
        // R9
        chk("R9 halted", 32'(halted), 1);
        chk("R9 illegal", 32'(illegal), 1);
        e = '{32'd1};
        chk_stream("R9", e);
    endtask

    task automatic t_timing();
        do_reset();
        put(0, w(8'h0A, 0, 0)); put(1, w(8'h0A, 0, 0)); put(2, w(8'h01, 0, 0));
        go();
        // R11: start sampled at start_cyc edge
        while (cyc < start_cyc + 5) @(negedge clk);
        chk("R11 not yet halted", 32'(halted), 0);
        @(negedge clk);
        chk("R11 halted cycle", 32'(halted), 1);
        chk("R11 pulse count", 32'(seen_cyc.size()), 2);
        if (seen_cyc.size() == 2) begin
            chk("R11 first emit", 32'(seen_cyc[0] - start_cyc), 2);
            chk("R11 second emit", 32'(seen_cyc[1] - start_cyc), 4);
        end
    endtask

    task automatic t_preload_ignored();
        logic [31:0] e[$];
        do_reset();
        put(0, w(8'h02, 0, 10)); put(1, w(8'h01, 0, 0));
        put(20, 32'd0);
        go();
        wait_stop(50);
        put(0, w(8'h0A, 0, 0));
        // R1: preload after start ignored; rerun via start has no effect
        go();
        repeat (10) @(negedge clk);
        e = {};
        chk_stream("R1 late preload", e);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_memory();
        t_branch();
        t_halt();
        t_illegal();
        t_timing();
        t_preload_ignored();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule